// File: doc/BRIEF.md
# Single-Bit Hamming Sector Check-Code Corrector

The block takes the recomputed 24-bit Hamming check code of a 512-byte sector and compares it with the code that was stored next to the sector. It reports what it found and, if one data bit is wrong, repairs that bit in a sector buffer. The recomputed code enters as the raw 32-bit word from the parity hardware. The block picks two 12-bit fields out of that word and inverts the result. Because of the inversion, a sector that reads all ones, together with an all-ones stored code, compares equal. The stored code arrives as three bytes. The block also returns the inverted recomputed code as three bytes, so that it can be written to the flash.

The user pulses `start_i` with the two codes present. One cycle later the block raises `res_valid_o` for one cycle, together with a 2-bit outcome and, for a repairable error, the byte and bit position. After a repairable outcome the block works on the buffer through a small port that takes one cycle to read. In the first cycle it reads the byte. In the second cycle it writes back that byte with the bit inverted. A start that arrives while a result or a repair is still in progress is ignored.

Top module: `ecc1_corrector`

## Requirements
- R1: `calc_b0_o`, `calc_b1_o` and `calc_b2_o` carry the bitwise inverse of {raw[27:16], raw[11:0]}, least significant byte in `calc_b0_o`. Raw bits 31:28 and 15:12 have no effect. The stored code is {stored_b2_i, stored_b1_i, stored_b0_i}, and the syndrome is the recomputed code XOR the stored code.
- R2: A raw word whose two code fields are zero, checked against a stored code of 0xFF in all three bytes, gives status 0.
- R3: A zero syndrome gives status 0 (clean), with `err_byte_o` and `err_bit_o` both 0.
- R4: If syndrome[23:12] XOR syndrome[11:0] equals 0xFFF and syndrome[23:15] is below SECTOR_BYTES, the status is 1 (data bit fixed), `err_byte_o` = syndrome[23:15] and `err_bit_o` = syndrome[14:12].
- R5: If that complement pattern names a byte index of SECTOR_BYTES or more, the status is 3 (uncorrectable) and the buffer is not accessed.
- R6: A syndrome with exactly one bit set gives status 2 (check code only). The buffer is neither read nor written.
- R7: Any other non-zero syndrome gives status 3 and leaves the buffer untouched.
- R8: `res_valid_o` is high for exactly one cycle, in the cycle after the clock edge that accepts `start_i`.
- R9: After a status-1 result, the next cycle asserts `buf_rd_en_o` with `buf_addr_o` = the byte index. The cycle after that asserts `buf_wr_en_o` at the same address, with `buf_wdata_o` = `buf_rdata_i` XOR (1 << bit index). The buffer returns read data one cycle after the read.
- R10: `start_i` is ignored while `res_valid_o` is high and while a buffer read or write is in progress.
- R11: After reset, `res_valid_o`, `buf_rd_en_o`, `buf_wr_en_o`, `res_status_o` and the calc bytes are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Evaluate the codes presented this cycle |
| raw_ecc_i | input | 32 | Raw parity word for the sector read back |
| stored_b0_i | input | 8 | Stored code, bits 7:0 |
| stored_b1_i | input | 8 | Stored code, bits 15:8 |
| stored_b2_i | input | 8 | Stored code, bits 23:16 |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_status_o | output | 2 | 0 clean, 1 data fixed, 2 code-only, 3 uncorrectable |
| err_byte_o | output | 9 | Byte index of the repaired bit |
| err_bit_o | output | 3 | Bit index within that byte |
| calc_b0_o | output | 8 | Recomputed inverted code, bits 7:0 |
| calc_b1_o | output | 8 | Recomputed inverted code, bits 15:8 |
| calc_b2_o | output | 8 | Recomputed inverted code, bits 23:16 |
| buf_rd_en_o | output | 1 | Sector buffer read strobe |
| buf_wr_en_o | output | 1 | Sector buffer write strobe |
| buf_addr_o | output | 9 | Sector buffer byte address |
| buf_wdata_o | output | 8 | Repaired byte to write |
| buf_rdata_i | input | 8 | Byte read from the buffer, one cycle after the read |

## Verification
Matching codes are tried with both an all-zero raw word and raw words whose unused nibbles are set. This separates correct field extraction from accidental use of bits 31:28 and 15:12. Complement syndromes at byte 0, byte 5 and byte 511 check the index slicing at both ends of the range. The same syndrome reached from two different raw words shows that the block depends only on the XOR of the two codes.

Single-bit syndromes at the lowest bit, the highest bit and the lowest bit of the upper half must give the code-only outcome and no buffer traffic. Two-bit and all-ones syndromes separate the uncorrectable case from both correctable paths. A second instance with a smaller sector places a complement syndrome past its end, to check the range rule. Holding start high through a repair shows that new requests are dropped while the block is busy.

// File: rtl/ecc1_pkg.sv
package ecc1_pkg;
    localparam int HALF_W  = 12;
    localparam int CODE_W  = 2 * HALF_W;
    localparam int NBYTES  = CODE_W / 8;
    localparam int BIT_W   = 3;
    localparam int BYTE_W  = HALF_W - BIT_W;

    typedef enum logic [1:0] {
        ST_CLEAN = 2'd0,
        ST_FIXED = 2'd1,
        ST_CODE  = 2'd2,
        ST_FATAL = 2'd3
    } ecc_status_e;

    typedef enum logic [1:0] {
        RMW_IDLE  = 2'd0,
        RMW_READ  = 2'd1,
        RMW_WRITE = 2'd2
    } rmw_phase_e;
endpackage

// File: rtl/ecc1_code_pack.sv
module ecc1_code_pack
    import ecc1_pkg::*;
#(
    parameter int RAW_W  = 32,
    parameter int HI_LSB = 16
) (
    input  logic [RAW_W-1:0]  raw_i,
    output logic [CODE_W-1:0] code_o
);
    localparam int LO_GAP = HI_LSB - HALF_W;
    localparam int HI_GAP = RAW_W - HI_LSB - HALF_W;

    logic [HALF_W-1:0] lo_field;
    logic [HALF_W-1:0] hi_field;
    logic              unused_spare;

    assign lo_field = raw_i[0 +: HALF_W];
    assign hi_field = raw_i[HI_LSB +: HALF_W];

    // Spare nibbles do not take part in the code.
    assign unused_spare = ^{raw_i[HALF_W +: LO_GAP], raw_i[RAW_W-1 -: HI_GAP]};

    // Inversion makes an erased sector match an erased stored code.
    assign code_o = ~{hi_field, lo_field};
endmodule

// File: rtl/ecc1_classify.sv
module ecc1_classify
    import ecc1_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic [CODE_W-1:0] syn_i,
    output ecc_status_e       status_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic [BIT_W-1:0]  bit_o
);
    localparam logic [BYTE_W:0] LIMIT = (BYTE_W+1)'(SECTOR_BYTES);

    logic [HALF_W-1:0] upper;
    logic [HALF_W-1:0] lower;
    logic              is_zero;
    logic              is_complement;
    logic              is_single;
    logic              in_range;
    logic [BYTE_W-1:0] byte_idx;
    logic [BIT_W-1:0]  bit_idx;

    assign upper     = syn_i[CODE_W-1 -: HALF_W];
    assign lower     = syn_i[HALF_W-1:0];
    assign byte_idx  = upper[HALF_W-1 -: BYTE_W];
    assign bit_idx   = upper[BIT_W-1:0];

    assign is_zero       = (syn_i == '0);
    assign is_complement = ((upper ^ lower) == {HALF_W{1'b1}});
    assign is_single     = !is_zero && ((syn_i & (syn_i - 1'b1)) == '0);
    assign in_range      = ({1'b0, byte_idx} < LIMIT);

    always_comb begin
        status_o = ST_FATAL;
        byte_o   = '0;
        bit_o    = '0;
        if (is_zero) begin
            status_o = ST_CLEAN;
        end else if (is_complement) begin
            if (in_range) begin
                status_o = ST_FIXED;
                byte_o   = byte_idx;
                bit_o    = bit_idx;
            end
        end else if (is_single) begin
            status_o = ST_CODE;
        end
    end
endmodule

// File: rtl/ecc1_rmw.sv
module ecc1_rmw
    import ecc1_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [BIT_W-1:0]  bit_i,
    input  logic [7:0]        rdata_i,
    output logic              rd_en_o,
    output logic              wr_en_o,
    output logic [BYTE_W-1:0] addr_o,
    output logic [7:0]        wdata_o,
    output logic              busy_o
);
    typedef struct packed {
        rmw_phase_e        phase;
        logic [BYTE_W-1:0] addr;
        logic [7:0]        mask;
    } rmw_state_t;

    rmw_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (st_q.phase)
            RMW_IDLE: begin
                if (go_i) begin
                    st_d.phase = RMW_READ;
                    st_d.addr  = byte_i;
                    st_d.mask  = 8'b1 << bit_i;
                end
            end
            RMW_READ:  st_d.phase = RMW_WRITE;
            RMW_WRITE: st_d.phase = RMW_IDLE;
            default:   st_d.phase = RMW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: RMW_IDLE, addr: '0, mask: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_en_o = (st_q.phase == RMW_READ);
    assign wr_en_o = (st_q.phase == RMW_WRITE);
    assign addr_o  = st_q.addr;
    assign wdata_o = rdata_i ^ st_q.mask;
    assign busy_o  = (st_q.phase != RMW_IDLE);
endmodule

// File: rtl/ecc1_corrector.sv
module ecc1_corrector
    import ecc1_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [31:0]       raw_ecc_i,
    input  logic [7:0]        stored_b0_i,
    input  logic [7:0]        stored_b1_i,
    input  logic [7:0]        stored_b2_i,
    output logic              res_valid_o,
    output logic [1:0]        res_status_o,
    output logic [BYTE_W-1:0] err_byte_o,
    output logic [BIT_W-1:0]  err_bit_o,
    output logic [7:0]        calc_b0_o,
    output logic [7:0]        calc_b1_o,
    output logic [7:0]        calc_b2_o,
    output logic              buf_rd_en_o,
    output logic              buf_wr_en_o,
    output logic [BYTE_W-1:0] buf_addr_o,
    output logic [7:0]        buf_wdata_o,
    input  logic [7:0]        buf_rdata_i
);
    typedef struct packed {
        logic              valid;
        ecc_status_e       status;
        logic [BYTE_W-1:0] byte_idx;
        logic [BIT_W-1:0]  bit_idx;
        logic [CODE_W-1:0] code;
    } res_t;

    logic [CODE_W-1:0]  calc_code;
    logic [CODE_W-1:0]  stored_code;
    logic [CODE_W-1:0]  syndrome;
    ecc_status_e        cls_status;
    logic [BYTE_W-1:0]  cls_byte;
    logic [BIT_W-1:0]   cls_bit;
    logic               rmw_busy;
    logic               accept;
    logic [NBYTES-1:0][7:0] stored_bytes;
    logic [NBYTES-1:0][7:0] calc_bytes;
    res_t res_d, res_q;

    ecc1_code_pack #(.RAW_W(32), .HI_LSB(16)) u_pack (
        .raw_i  (raw_ecc_i),
        .code_o (calc_code)
    );

    assign stored_bytes = {stored_b2_i, stored_b1_i, stored_b0_i};

    genvar gi;
    generate
        for (gi = 0; gi < NBYTES; gi++) begin : g_bytes
            assign stored_code[gi*8 +: 8] = stored_bytes[gi];
            assign calc_bytes[gi]         = res_q.code[gi*8 +: 8];
        end
    endgenerate

    assign syndrome = calc_code ^ stored_code;

    ecc1_classify #(.SECTOR_BYTES(SECTOR_BYTES)) u_cls (
        .syn_i    (syndrome),
        .status_o (cls_status),
        .byte_o   (cls_byte),
        .bit_o    (cls_bit)
    );

    assign accept = start_i && !res_q.valid && !rmw_busy;

    always_comb begin
        res_d       = res_q;
        res_d.valid = 1'b0;
        if (accept) begin
            res_d.valid    = 1'b1;
            res_d.status   = cls_status;
            res_d.byte_idx = cls_byte;
            res_d.bit_idx  = cls_bit;
            res_d.code     = calc_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '{valid: 1'b0, status: ST_CLEAN, byte_idx: '0,
                       bit_idx: '0, code: '0};
        end else begin
            res_q <= res_d;
        end
    end

    ecc1_rmw u_rmw (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (res_q.valid && (res_q.status == ST_FIXED)),
        .byte_i  (res_q.byte_idx),
        .bit_i   (res_q.bit_idx),
        .rdata_i (buf_rdata_i),
        .rd_en_o (buf_rd_en_o),
        .wr_en_o (buf_wr_en_o),
        .addr_o  (buf_addr_o),
        .wdata_o (buf_wdata_o),
        .busy_o  (rmw_busy)
    );

    assign res_valid_o  = res_q.valid;
    assign res_status_o = res_q.status;
    assign err_byte_o   = res_q.byte_idx;
    assign err_bit_o    = res_q.bit_idx;
    assign calc_b0_o    = calc_bytes[0];
    assign calc_b1_o    = calc_bytes[1];
    assign calc_b2_o    = calc_bytes[2];
endmodule

// File: rtl/ecc1_corrector_chk.sv
module ecc1_corrector_chk
    import ecc1_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        stored_b0_i,
    input logic [7:0]        stored_b1_i,
    input logic [7:0]        stored_b2_i,
    input logic              res_valid_o,
    input logic [1:0]        res_status_o,
    input logic [BYTE_W-1:0] err_byte_o,
    input logic [7:0]        calc_b0_o,
    input logic [7:0]        calc_b1_o,
    input logic [7:0]        calc_b2_o,
    input logic              buf_rd_en_o,
    input logic              buf_wr_en_o,
    input logic [BYTE_W-1:0] buf_addr_o,
    input logic [7:0]        buf_wdata_o,
    input logic [7:0]        buf_rdata_i
);
    assert_clean_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && res_status_o == 2'd0) |->
        ({calc_b2_o, calc_b1_o, calc_b0_o} ==
         {$past(stored_b2_i), $past(stored_b1_i), $past(stored_b0_i)}));

    assert_index_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && res_status_o == 2'd1) |->
        (32'(err_byte_o) < SECTOR_BYTES));

    assert_no_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && res_status_o != 2'd1) |=> (!buf_rd_en_o && !buf_wr_en_o));

    assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o);

    assert_read_after_fix_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && res_status_o == 2'd1) |=>
        (buf_rd_en_o && buf_addr_o == $past(err_byte_o)));

    assert_write_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_en_o |=> (buf_wr_en_o && $stable(buf_addr_o)));

    assert_single_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en_o |-> ($countones(buf_wdata_o ^ buf_rdata_i) == 1));

    assert_rd_wr_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_rd_en_o && buf_wr_en_o));

    assert_busy_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd_en_o || buf_wr_en_o) |=> !res_valid_o);
endmodule

bind ecc1_corrector ecc1_corrector_chk #(.SECTOR_BYTES(SECTOR_BYTES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .stored_b0_i  (stored_b0_i),
    .stored_b1_i  (stored_b1_i),
    .stored_b2_i  (stored_b2_i),
    .res_valid_o  (res_valid_o),
    .res_status_o (res_status_o),
    .err_byte_o   (err_byte_o),
    .calc_b0_o    (calc_b0_o),
    .calc_b1_o    (calc_b1_o),
    .calc_b2_o    (calc_b2_o),
    .buf_rd_en_o  (buf_rd_en_o),
    .buf_wr_en_o  (buf_wr_en_o),
    .buf_addr_o   (buf_addr_o),
    .buf_wdata_o  (buf_wdata_o),
    .buf_rdata_i  (buf_rdata_i)
);

// File: tb/tb_ecc1_corrector.sv
module tb_ecc1_corrector;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        start_small = 1'b0;
    logic [31:0] raw = '0;
    logic [23:0] stored = '0;
    logic        valid, valid_s;
    logic [1:0]  status, status_s;
    logic [8:0]  ebyte, ebyte_s;
    logic [2:0]  ebit, ebit_s;
    logic [7:0]  c0, c1, c2, c0_s, c1_s, c2_s;
    logic        rd_en, wr_en, rd_en_s, wr_en_s;
    logic [8:0]  addr, addr_s;
    logic [7:0]  wdata, wdata_s;
    logic [7:0]  rdata;

    int checks = 0;
    int errors = 0;
    int writes = 0;
    logic [7:0] mem [512];
    logic [7:0] exp_mem [512];

    always #10 clk = ~clk;

    ecc1_corrector dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .raw_ecc_i(raw),
        .stored_b0_i(stored[7:0]), .stored_b1_i(stored[15:8]), .stored_b2_i(stored[23:16]),
        .res_valid_o(valid), .res_status_o(status), .err_byte_o(ebyte), .err_bit_o(ebit),
        .calc_b0_o(c0), .calc_b1_o(c1), .calc_b2_o(c2),
        .buf_rd_en_o(rd_en), .buf_wr_en_o(wr_en), .buf_addr_o(addr),
        .buf_wdata_o(wdata), .buf_rdata_i(rdata)
    );

    ecc1_corrector #(.SECTOR_BYTES(256)) dut_small (
        .clk(clk), .rst_n(rst_n), .start_i(start_small), .raw_ecc_i(raw),
        .stored_b0_i(stored[7:0]), .stored_b1_i(stored[15:8]), .stored_b2_i(stored[23:16]),
        .res_valid_o(valid_s), .res_status_o(status_s), .err_byte_o(ebyte_s), .err_bit_o(ebit_s),
        .calc_b0_o(c0_s), .calc_b1_o(c1_s), .calc_b2_o(c2_s),
        .buf_rd_en_o(rd_en_s), .buf_wr_en_o(wr_en_s), .buf_addr_o(addr_s),
        .buf_wdata_o(wdata_s), .buf_rdata_i(8'h00)
    );

    // Sector buffer model: one cycle read latency.
    always @(posedge clk) begin
        if (rd_en) rdata <= mem[addr];
        if (wr_en) begin
            mem[addr] <= wdata;
            writes    <= writes + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Columns: raw word, stored code, status, byte index, bit index.
    localparam int NV = 12;
    localparam logic [69:0] VEC [NV] = '{
        {32'h0000_0000, 24'hFFFFFF, 2'd0, 9'd0,   3'd0},  // R2 erased
        {32'hFABC_F123, 24'h543EDC, 2'd0, 9'd0,   3'd0},  // R1 spare nibbles set
        {32'h0ABC_0123, 24'h543EDC, 2'd0, 9'd0,   3'd0},  // R3
        {32'h0000_0000, 24'hFD402B, 2'd1, 9'd5,   3'd3},  // R4
        {32'h0000_0000, 24'h000FFF, 2'd1, 9'd511, 3'd7},  // R4 top byte
        {32'h0000_0000, 24'hFFF000, 2'd1, 9'd0,   3'd0},  // R4 byte 0
        {32'h0ABC_0123, 24'h568108, 2'd1, 9'd5,   3'd3},  // R4 other raw
        {32'h0000_0000, 24'hFFFFFE, 2'd2, 9'd0,   3'd0},  // R6 lowest bit
        {32'h0000_0000, 24'h7FFFFF, 2'd2, 9'd0,   3'd0},  // R6 highest bit
        {32'h0000_0000, 24'hFFEFFF, 2'd2, 9'd0,   3'd0},  // R6 bit 12
        {32'h0000_0000, 24'hFFFFFC, 2'd3, 9'd0,   3'd0},  // R7 two bits
        {32'h0000_0000, 24'h000000, 2'd3, 9'd0,   3'd0}   // R7 all ones
    };

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [23:0] exp_code;
        logic [1:0]  es;
        logic [8:0]  eb;
        logic [2:0]  ei;
        int          w0;
        for (int i = 0; i < 512; i++) begin
            mem[i]     = 8'((i * 7 + 3) & 8'hFF);
            exp_mem[i] = 8'((i * 7 + 3) & 8'hFF);
        end
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 valid", 32'(valid), 0);
        check("R11 rd/wr", 32'({rd_en, wr_en}), 0);
        check("R11 status", 32'(status), 0);
        check("R11 calc", 32'({c2, c1, c0}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            {r, stored, es, eb, ei} = VEC[v];
            raw      = r;
            exp_code = ~{r[27:16], r[11:0]};
            w0       = writes;
            start    = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check("R8 valid", 32'(valid), 1);
            check("R1 calc code", 32'({c2, c1, c0}), 32'(exp_code));
            check("R3/R4/R6/R7 status", 32'(status), 32'(es));
            check("R4 byte", 32'(ebyte), 32'(eb));
            check("R4 bit", 32'(ebit), 32'(ei));
            @(negedge clk);
            check("R8 pulse width", 32'(valid), 0);
            check("R9 read strobe", 32'(rd_en), 32'(es == 2'd1));
            if (es == 2'd1) check("R9 read addr", 32'(addr), 32'(eb));
            @(negedge clk);
            check("R9 write strobe", 32'(wr_en), 32'(es == 2'd1));
            @(negedge clk);
            if (es == 2'd1) exp_mem[eb] = exp_mem[eb] ^ (8'b1 << ei);
            check("R9/R6/R7 write count", 32'(writes - w0), 32'(es == 2'd1));
            check("R9 buffer byte", 32'(mem[eb]), 32'(exp_mem[eb]));
        end

        // R10: start held through a repair is ignored until idle.
        raw = 32'h0; stored = 24'hFD402B; w0 = writes;
        start = 1'b1;
        @(negedge clk);
        stored = 24'hFFFFFF;
        check("R10 first accepted", 32'(valid), 1);
        @(negedge clk);
        check("R10 ignored while valid", 32'(valid), 0);
        @(negedge clk);
        start = 1'b0;
        check("R10 ignored during read", 32'(valid), 0);
        @(negedge clk);
        check("R10 ignored during write", 32'(valid), 0);
        check("R10 single repair", 32'(writes - w0), 1);
        exp_mem[5] = exp_mem[5] ^ 8'h08;
        check("R10 buffer byte", 32'(mem[5]), 32'(exp_mem[5]));

        // R5: sector of 256 bytes, index 300 out of range, 255 in range.
        raw = 32'h0; stored = 24'h69D962;
        start_small = 1'b1;
        @(negedge clk);
        start_small = 1'b0;
        check("R5 out of range status", 32'(status_s), 3);
        check("R5 out of range byte", 32'(ebyte_s), 0);
        @(negedge clk);
        check("R5 no read", 32'(rd_en_s), 0);
        @(negedge clk);
        check("R5 no write", 32'(wr_en_s), 0);
        stored = 24'h8067F9;
        start_small = 1'b1;
        @(negedge clk);
        start_small = 1'b0;
        check("R5 last byte status", 32'(status_s), 1);
        check("R5 last byte index", 32'(ebyte_s), 255);
        check("R5 last byte bit", 32'(ebit_s), 1);
        repeat (3) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule